// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block models a single-port synchronous static RAM whose 36-bit word is split into four 9-bit lanes. Address, control and write data are all captured in input registers on the rising clock edge. A write is carried out at the following edge, so a write cycle never overlaps a read of the same location. A read returns its word through an output register. The data path is pipelined, and a new access can start on every clock.

Three chip-select inputs, two active low and one active high, must all be active for a cycle to take effect. The shared three-state data bus is modelled as separate `din` and `dout` ports. An output-enable flag, `dout_oe`, tells the surrounding pad logic when `dout` should be driven. The flag goes high only for a selected read. It falls one cycle after a deselect or a write cycle is sampled. While `dout_oe` is low, `dout` holds the last word that was read.

A write can cover any subset of the four lanes. The all-lanes write control overrides the per-lane controls. Without it, the byte-write control gates each lane select.

Top module: `ssram_pipe`

## Requirements
- R1: A cycle is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A cycle that is not selected writes no lane and does not raise `dout_oe`.
- R2: On a selected cycle with `all_wr_n`=0, all four lanes of the addressed word take `din`, whatever the values of `byte_wr_n` and `lane_wr_n`.
- R3: On a selected cycle with `all_wr_n`=1 and `byte_wr_n`=0, lane i is written exactly when `lane_wr_n[i]`=0. Lane i occupies bits 9i+8 down to 9i, and the other lanes keep their contents.
- R4: A selected cycle with `all_wr_n`=1 and `byte_wr_n`=1 is a read and changes no stored data.
- R5: For a selected read sampled at clock edge N, `dout` equals the stored word and `dout_oe` is 1 after edge N+1.
- R6: For a selected write cycle sampled at edge N, `dout_oe` is 0 after edge N+1.
- R7: For a deselected cycle sampled at edge N, `dout_oe` is 0 after edge N+1.
- R8: A read sampled at the edge immediately after a write to the same address returns the newly written lanes merged with the old lanes.
- R9: While `rst_n` is low, `dout_oe` is 0 and `dout` is 0.
- R10: `dout` changes only after an edge that completes a selected read. After any other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adr | input | ADDR_W | Word address |
| all_wr_n | input | 1 | Write all four lanes, active low |
| byte_wr_n | input | 1 | Byte-write control gating lane selects, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| din | input | 36 | Write data, bus inbound side |
| dout | output | 36 | Read data from output register |
| dout_oe | output | 1 | Bus drive enable for `dout` |

## Verification
The case hardest to reach from the ports is a write whose lanes land at one edge while the next cycle's read of the same word is already sitting in the input register. A missing lane, a stale word or a bypass error shows only in that back-to-back order. The bench sweeps all sixteen lane masks as write-then-read pairs on consecutive cycles, each on a word preloaded with a known pattern, so every merge of old and new lanes is seen. Every non-selecting combination of the three chip selects is also paired with an all-lanes write and then read back, to show that nothing was stored.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // internal, active-high view of one cycle's controls
  typedef struct packed {
    logic             sel;
    logic             all_wr;
    logic             byte_wr;
    logic [LANES-1:0] lane_wr;
  } ctrl_t;

  function automatic logic [LANES-1:0] lane_enables(input ctrl_t c);
    logic [LANES-1:0] en;
    for (int i = 0; i < LANES; i++)
      en[i] = c.sel & (c.all_wr | (c.byte_wr & c.lane_wr[i]));
    return en;
  endfunction
endpackage

// File: rtl/ssram_in_reg.sv
module ssram_in_reg
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_a_n,
  input  logic                   cs_b,
  input  logic                   cs_c_n,
  input  logic [ADDR_W-1:0]      adr,
  input  logic                   all_wr_n,
  input  logic                   byte_wr_n,
  input  logic [LANES-1:0]       lane_wr_n,
  input  logic [WORD_W-1:0]      din,
  output ctrl_t                  ctrl_q,
  output logic [ADDR_W-1:0]      adr_q,
  output logic [WORD_W-1:0]      din_q
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d.sel     = ~cs_a_n & cs_b & ~cs_c_n;
    ctrl_d.all_wr  = ~all_wr_n;
    ctrl_d.byte_wr = ~byte_wr_n;
    ctrl_d.lane_wr = ~lane_wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    adr_q <= adr;
    din_q <= din;
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   adr,
  input  logic [LANES-1:0]    lane_en,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_en[g]) mem[adr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[adr];
  end
endmodule

// File: rtl/ssram_out_reg.sv
module ssram_out_reg
  import ssram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe
);
  logic [WORD_W-1:0] dout_d;
  logic              oe_d;

  always_comb begin
    dout_d = dout;
    if (rd_en) dout_d = rd_word;
    oe_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_oe <= oe_d;
    end
  end
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_a_n,
  input  logic                cs_b,
  input  logic                cs_c_n,
  input  logic [ADDR_W-1:0]   adr,
  input  logic                all_wr_n,
  input  logic                byte_wr_n,
  input  logic [3:0]          lane_wr_n,
  input  logic [35:0]         din,
  output logic [35:0]         dout,
  output logic                dout_oe
);
  ctrl_t               ctrl_q;
  logic [ADDR_W-1:0]   adr_q;
  logic [WORD_W-1:0]   din_q;
  logic [LANES-1:0]    lane_en;
  logic [WORD_W-1:0]   rd_word;
  logic                rd_en;

  ssram_in_reg #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .adr(adr), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
    .lane_wr_n(lane_wr_n), .din(din),
    .ctrl_q(ctrl_q), .adr_q(adr_q), .din_q(din_q)
  );

  always_comb begin
    lane_en = lane_enables(ctrl_q);
    rd_en   = ctrl_q.sel & ~ctrl_q.all_wr & ~ctrl_q.byte_wr;
  end

  ssram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .adr(adr_q), .lane_en(lane_en),
    .wdata(din_q), .rdata(rd_word)
  );

  ssram_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_word(rd_word),
    .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/ssram_pipe_chk.sv
module ssram_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_a_n,
  input logic        cs_b,
  input logic        cs_c_n,
  input logic        all_wr_n,
  input logic        byte_wr_n,
  input logic [35:0] dout,
  input logic        dout_oe
);
  logic sel_in;
  assign sel_in = ~cs_a_n & cs_b & ~cs_c_n;

  p_read_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && all_wr_n && byte_wr_n) |-> ##2 dout_oe);

  p_write_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && (!all_wr_n || !byte_wr_n)) |-> ##2 !dout_oe);

  p_deselect_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |-> ##2 !dout_oe);

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> $stable(dout));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> (!dout_oe && dout == '0));
endmodule

bind ssram_pipe ssram_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
  .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/ssram_pipe_tb_top.sv
module ssram_pipe_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_a_n, cs_b, cs_c_n, all_wr_n, byte_wr_n;
  logic [AW-1:0] adr;
  logic [3:0]  lane_wr_n;
  logic [35:0] din, dout;
  logic        dout_oe;

  always #5 clk = ~clk;

  ssram_pipe #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .adr(adr), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
    .lane_wr_n(lane_wr_n), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [35:0] model [NW];
  logic [35:0] last_rd;

  // expectation pipe: index 1 is due at the current sample point
  logic        p_oe   [2];
  logic [35:0] p_data [2];
  string       p_tag  [2];
  logic        p_vld  [2];

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: at a falling edge, check the op from two steps back,
  // then apply this op and advance to the next falling edge
  task automatic step(input string tag, input logic a_n, input logic b, input logic c_n,
                      input logic [AW-1:0] a, input logic aw_n, input logic bw_n,
                      input logic [3:0] ln_n, input logic [35:0] d);
    logic sel, rd;
    logic [35:0] w;
    if (p_vld[1]) begin
      chk({p_tag[1], " oe"}, {35'd0, dout_oe}, {35'd0, p_oe[1]});
      chk({p_tag[1], " data"}, dout, p_data[1]);
    end
    sel = !a_n && b && !c_n;
    rd  = sel && aw_n && bw_n;
    if (sel && !rd) begin
      w = model[a];
      for (int i = 0; i < 4; i++)
        if (!aw_n || !ln_n[i]) w[i*9 +: 9] = d[i*9 +: 9];
      model[a] = w;
    end
    if (rd) last_rd = model[a];
    p_oe[1] = p_oe[0]; p_data[1] = p_data[0]; p_tag[1] = p_tag[0]; p_vld[1] = p_vld[0];
    p_oe[0] = rd; p_data[0] = last_rd; p_tag[0] = tag; p_vld[0] = 1'b1;
    cs_a_n = a_n; cs_b = b; cs_c_n = c_n; adr = a;
    all_wr_n = aw_n; byte_wr_n = bw_n; lane_wr_n = ln_n; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_op(input string tag, input logic [AW-1:0] a);
    step(tag, 1'b0, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, 36'h0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, 4'h0, 36'hF_FFFF_FFFF);
  endtask

  function automatic logic [35:0] pat(input int k);
    return {4'(k), 32'(k * 32'h9E37_79B9 + 32'h1234_5678)};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    p_vld[0] = 1'b0; p_vld[1] = 1'b0;
    p_oe[0] = 1'b0; p_oe[1] = 1'b0;
    p_data[0] = '0; p_data[1] = '0;
    p_tag[0] = ""; p_tag[1] = "";
    last_rd = '0;
    rst_n = 1'b0;
    cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1; adr = '0;
    all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_wr_n = 4'hF; din = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset oe", {35'd0, dout_oe}, 36'd0);
    chk("R9 reset data", dout, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: fill every word with all-lanes writes, lane controls scrambled
    for (int a = 0; a < NW; a++)
      step("R2 fill", 1'b0, 1'b1, 1'b0, AW'(a), 1'b0, a[0], 4'(a), pat(a));
    // R5 R6: read every word back, pipelined
    for (int a = 0; a < NW; a++) rd_op("R5 readback", AW'(a));

    // R3 R8: every lane mask, write then read on the next cycle
    for (int m = 0; m < 16; m++) begin
      step("R3 R8 lane write", 1'b0, 1'b1, 1'b0, AW'(m), 1'b1, 1'b0, 4'(m), ~pat(m + 100));
      rd_op("R3 R8 lane read", AW'(m));
    end

    // R4: both write controls inactive is a read, lane selects ignored
    step("R4 read with lanes low", 1'b0, 1'b1, 1'b0, AW'(20), 1'b1, 1'b1, 4'h0, 36'h0);
    rd_op("R4 data kept", AW'(20));

    // R1 R7 R10: every non-selecting combination tries an all-lanes write
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        step("R1 R7 deselected write", c[2], c[1], c[0], AW'(30 + c), 1'b0, 1'b0, 4'h0, 36'h0);
        idle("R10 hold");
        rd_op("R1 no store", AW'(30 + c));
      end
    end

    // R8: write followed by read of same word, two in a row
    step("R8 write a", 1'b0, 1'b1, 1'b0, AW'(50), 1'b0, 1'b1, 4'hF, 36'hA_5A5A_5A5A);
    rd_op("R8 read a", AW'(50));
    step("R8 write b", 1'b0, 1'b1, 1'b0, AW'(50), 1'b1, 1'b0, 4'b0110, 36'h0_0000_0000);
    rd_op("R8 read b", AW'(50));

    idle("R7 flush");
    idle("R7 flush");
    idle("R7 flush");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule